// File: doc/BRIEF.md
# Mesh vertex scan sequencer

This block drives a programmable vertex processor across a two-dimensional mesh. A host programs a destination base address, the last column and row indices of the mesh and a microcode page number, then sets a start bit. The sequencer visits every vertex, row by row. For each vertex it loads the column and row numbers into general registers 0 and 1 of the processor core. It then runs the microcode program from address 0, one instruction per cycle, until the core reaches a vector-output instruction.

On a vector output the sequencer takes the two 32-bit operand values from the core. It writes them, byte-swapped to big-endian order, into two consecutive words of memory. The memory side uses a request/acknowledge handshake. The destination is a fixed 128-column mesh with an 8-byte vertex stride. A program that runs too long without a vector output is abandoned and flagged, and the sweep carries on. When every vertex has been visited, the sequencer stores the vertex count and issues a one-cycle interrupt. The arithmetic core and the memory bus are outside this block.

Top module: `mesh_scan_seq`

## Requirements
- R1: After reset, irq, mem_req, gpr_we and run_en are 0, and every readable register (control at address 0, base 1, last column 2, last row 3, page 4, vertex count 5, last write address 6) reads 0.
- R2: A host write to address 0 with bit 0 set while idle starts a sweep; control bit 0 reads 1 from the next cycle until the sweep ends.
- R3: Vertices are visited row-major: y runs from 0 to the last row inclusive (outer), and x runs from 0 to the last column inclusive (inner).
- R4: Before each vertex run there is one cycle with gpr_we=1, gpr_idx=0 and gpr_wdata=x, and the next cycle has gpr_we=1, gpr_idx=1 and gpr_wdata=y.
- R5: During a run, run_en is 1 and ucode_addr equals page × 2^PAGE_W + pc, taken modulo 2^CODE_AW. The pc starts at 0 for every vertex and advances by one for each executed instruction.
- R6: A run ends on the first executed instruction whose opcode field insn[10:7] equals 7 (vector output); that instruction is counted as executed.
- R7: Each vector output causes two memory writes. The first goes to base + 8·(2^COLS_LOG2·y + x) with the byte-swapped vout_a; the second goes to that address + 4 with the byte-swapped vout_b. Each request is held stable until mem_ack.
- R8: After the second write is acknowledged, register 6 holds the address of that second word.
- R9: If LIMIT instructions execute without a vector output, the run is abandoned with no memory write, the sweep moves to the next vertex, and control bit 1 reads 1 until the next start.
- R10: At the end of a sweep, register 5 holds (last column + 1)·(last row + 1), irq is high for exactly one cycle, and control bit 0 reads 0 in that same cycle.
- R11: Host writes to any register while a sweep is in progress are ignored: no restart, no change to addresses or to the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | 3 | Host register address (write and read) |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Readback of the register at cfg_addr |
| gpr_we | output | 1 | Load a core general register |
| gpr_idx | output | GPR_W | Index of the general register being loaded |
| gpr_wdata | output | 32 | Value loaded (x or y) |
| run_en | output | 1 | Core executes the instruction at ucode_addr this cycle |
| ucode_addr | output | CODE_AW | Microcode fetch address |
| insn | input | 32 | Instruction word at ucode_addr |
| vout_a | input | 32 | First vector-output operand value |
| vout_b | input | 32 | Second vector-output operand value |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data, big-endian |
| mem_ack | input | 1 | Memory write accepted |
| irq | output | 1 | One-cycle sweep-complete pulse |

## Verification
The bench builds the block with IDX_W=3, PAGE_W=4, CODE_AW=6 and LIMIT=12. Under these settings, every mesh shape from 1×1 to 4×4 can be swept in full, along with the full 8×8 mesh at the largest index. Every program length from a vector output at pc 0 up to an abandoned run at the limit also fits in a short simulation. Every microcode page is reached as well. A small limit makes the abort path cheap to reach. The bench computes each address, each byte-swapped word, each instruction count and each vertex count arithmetically from the sweep settings. One sweep also writes new settings and a second start while busy, to show that they have no effect.

// File: rtl/mesh_scan_seq.sv
module mesh_scan_seq #(
  parameter int IDX_W     = 7,
  parameter int COLS_LOG2 = 7,
  parameter int PAGE_W    = 9,
  parameter int CODE_AW   = 11,
  parameter int LIMIT     = 2048,
  parameter int GPR_W     = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               gpr_we,
  output logic [GPR_W-1:0]   gpr_idx,
  output logic [31:0]        gpr_wdata,
  output logic               run_en,
  output logic [CODE_AW-1:0] ucode_addr,
  input  logic [31:0]        insn,
  input  logic [31:0]        vout_a,
  input  logic [31:0]        vout_b,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_data,
  input  logic               mem_ack,
  output logic               irq
);
  localparam int PG_W = CODE_AW - PAGE_W;
  localparam logic [3:0] OP_VOUT = 4'd7;
  localparam logic [CODE_AW-1:0] PC_LAST = CODE_AW'(LIMIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_LDX, S_LDY, S_RUN, S_WR0, S_WR1} st_t;
  st_t st;

  logic [31:0]        base, vcount, lastdma, va, vb, vaddr, lin;
  logic [IDX_W-1:0]   hlast, vlast, x, y;
  logic [PG_W-1:0]    page;
  logic [CODE_AW-1:0] pc;
  logic               err;

  wire busy    = (st != S_IDLE);
  wire is_vout = (insn[10:7] == OP_VOUT);
  wire start   = cfg_we && !busy && cfg_addr == 3'd0 && cfg_wdata[0];
  wire last_x  = (x == hlast);
  wire last_y  = (y == vlast);
  wire advance = (st == S_RUN && !is_vout && pc == PC_LAST) ||
                 (st == S_WR1 && mem_ack);

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign lin        = (32'(y) << COLS_LOG2) + 32'(x);
  assign vaddr      = base + (lin << 3);
  assign gpr_we     = (st == S_LDX) || (st == S_LDY);
  assign gpr_idx    = (st == S_LDY) ? GPR_W'(1) : GPR_W'(0);
  assign gpr_wdata  = (st == S_LDY) ? 32'(y) : 32'(x);
  assign run_en     = (st == S_RUN);
  assign ucode_addr = CODE_AW'({page, {PAGE_W{1'b0}}}) + pc;
  assign mem_req    = (st == S_WR0) || (st == S_WR1);
  assign mem_addr   = (st == S_WR1) ? vaddr + 32'd4 : vaddr;
  assign mem_data   = (st == S_WR1) ? bswap(vb) : bswap(va);

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {30'd0, err, busy};
      3'd1:    cfg_rdata = base;
      3'd2:    cfg_rdata = 32'(hlast);
      3'd3:    cfg_rdata = 32'(vlast);
      3'd4:    cfg_rdata = 32'(page);
      3'd5:    cfg_rdata = vcount;
      3'd6:    cfg_rdata = lastdma;
      default: cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      hlast <= '0;
      vlast <= '0;
      page  <= '0;
    end else if (cfg_we && !busy) begin
      case (cfg_addr)
        3'd1: base  <= cfg_wdata;
        3'd2: hlast <= cfg_wdata[IDX_W-1:0];
        3'd3: vlast <= cfg_wdata[IDX_W-1:0];
        3'd4: page  <= cfg_wdata[PG_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      x       <= '0;
      y       <= '0;
      pc      <= '0;
      va      <= '0;
      vb      <= '0;
      err     <= 1'b0;
      vcount  <= '0;
      lastdma <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          x   <= '0;
          y   <= '0;
          err <= 1'b0;
          st  <= S_LDX;
        end
        S_LDX: st <= S_LDY;
        S_LDY: begin
          pc <= '0;
          st <= S_RUN;
        end
        S_RUN: begin
          if (is_vout) begin
            va <= vout_a;
            vb <= vout_b;
            st <= S_WR0;
          end else if (pc == PC_LAST) begin
            err <= 1'b1;
          end else begin
            pc <= pc + 1'b1;
          end
        end
        S_WR0: if (mem_ack) st <= S_WR1;
        S_WR1: if (mem_ack) lastdma <= vaddr + 32'd4;
        default: st <= S_IDLE;
      endcase
      if (advance) begin
        if (last_x) begin
          x <= '0;
          if (last_y) begin
            st     <= S_IDLE;
            irq    <= 1'b1;
            vcount <= 32'((32'(hlast) + 32'd1) * (32'(vlast) + 32'd1));
          end else begin
            y  <= y + 1'b1;
            st <= S_LDX;
          end
        end else begin
          x  <= x + 1'b1;
          st <= S_LDX;
        end
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) $rose(rst_n) |-> !irq && !mem_req && !gpr_we && !run_en);
  a_r4_x_then_y: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we && gpr_idx == GPR_W'(0) |=> gpr_we && gpr_idx == GPR_W'(1));
  a_r5_pc_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we && gpr_idx == GPR_W'(1) |=> run_en && ucode_addr == CODE_AW'({page, {PAGE_W{1'b0}}}));
  a_r6_vout_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && is_vout |=> mem_req && !run_en);
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));
  a_r7_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WR0 && mem_ack |=> mem_req && mem_addr == $past(mem_addr) + 32'd4);
  a_r9_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !is_vout && pc == PC_LAST |=> !mem_req && cfg_rdata[1] == (cfg_addr == 3'd0));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  a_r10_idle_on_irq: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !busy && $past(busy));
endmodule

// File: tb/tb_mesh_scan_seq.sv
`timescale 1ns/1ps
module tb_mesh_scan_seq;
  localparam int IDX_W = 3, COLS_LOG2 = 7, PAGE_W = 4, CODE_AW = 6, LIMIT = 12, GPR_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0, cfg_rdata;
  logic gpr_we, run_en, mem_req, irq;
  logic mem_ack = 1'b0;
  logic [GPR_W-1:0] gpr_idx;
  logic [31:0] gpr_wdata, insn, vout_a, vout_b, mem_addr, mem_data;
  logic [CODE_AW-1:0] ucode_addr;

  int total = 0, bad = 0;
  int cur_base, cur_h, cur_v, cur_page, runlen, exp_run;
  int k, runcnt, beats, irq_cnt, ex, ey, wt;
  logic prev_irq = 1'b0;
  logic [7:0] gx = 8'd0, gy = 8'd0;

  always #2.5 clk = ~clk;

  mesh_scan_seq #(.IDX_W(IDX_W), .COLS_LOG2(COLS_LOG2), .PAGE_W(PAGE_W), .CODE_AW(CODE_AW),
                  .LIMIT(LIMIT), .GPR_W(GPR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_wdata(gpr_wdata),
    .run_en(run_en), .ucode_addr(ucode_addr), .insn(insn), .vout_a(vout_a), .vout_b(vout_b),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack), .irq(irq));

  assign insn   = (int'(ucode_addr) == cur_page * 16 + runlen) ? {21'h0ABCD, 4'd7, 7'd0}
                                                               : {21'h0ABCD, 4'd3, 7'd9};
  assign vout_a = {8'hA5, gx, gy, 8'h3C};
  assign vout_b = {8'h5A, 8'hC3, gy, gx};

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] vad(input int b, input int xx, input int yy);
    return 32'(b + 8 * (128 * yy + xx));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (gpr_we && gpr_idx == 0) begin
        if (k > 0) chk("R5 instructions per vertex", 32'(runcnt), 32'(exp_run));
        ex = k % (cur_h + 1);
        ey = k / (cur_h + 1);
        k++;
        chk("R3/R4 x load", gpr_wdata, 32'(ex));
        gx = gpr_wdata[7:0];
      end else if (gpr_we && gpr_idx == 1) begin
        chk("R3/R4 y load", gpr_wdata, 32'(ey));
        gy = gpr_wdata[7:0];
        runcnt = 0;
      end else if (gpr_we) begin
        chk("R4 register index", 32'(gpr_idx), 32'd1);
      end
      if (run_en) begin
        chk("R5 fetch address", 32'(ucode_addr), 32'(cur_page * 16 + runcnt));
        runcnt++;
      end
      if (mem_req && !mem_ack) begin
        if (wt == 1) begin
          mem_ack = 1'b1;
          wt = 0;
          if (beats % 2 == 0) begin
            chk("R7 first address", mem_addr, vad(cur_base, ex, ey));
            chk("R7 first data", mem_data, bsw({8'hA5, 8'(ex), 8'(ey), 8'h3C}));
          end else begin
            chk("R7 second address", mem_addr, vad(cur_base, ex, ey) + 32'd4);
            chk("R7 second data", mem_data, bsw({8'h5A, 8'hC3, 8'(ey), 8'(ex)}));
          end
          beats++;
        end else wt = 1;
      end else mem_ack = 1'b0;
      if (irq) begin
        irq_cnt++;
        chk("R10 pulse single", 32'(prev_irq), 32'd0);
        chk("R10 last run length", 32'(runcnt), 32'(exp_run));
        chk("R3 vertices visited", 32'(k), 32'((cur_h + 1) * (cur_v + 1)));
      end
      prev_irq = irq;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = 3'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic sweep(input int b, input int h, input int v, input int pg, input int rl, input bit busywr);
    logic [31:0] d;
    int c0;
    cur_base = b; cur_h = h; cur_v = v; cur_page = pg; runlen = rl;
    exp_run = (rl >= LIMIT) ? LIMIT : rl + 1;
    k = 0; beats = 0; runcnt = 0;
    wr(1, 32'(b)); wr(2, 32'(h)); wr(3, 32'(v)); wr(4, 32'(pg));
    c0 = irq_cnt;
    wr(0, 32'd1);
    rd(0, d);
    chk("R2 busy after start", {31'd0, d[0]}, 32'd1);
    if (busywr) begin
      wr(1, 32'hDEAD0000); wr(2, 32'd0); wr(0, 32'd1);
      rd(1, d);
      chk("R11 base unchanged while busy", d, 32'(b));
    end
    while (irq_cnt == c0) @(negedge clk);
    rd(0, d);
    chk("R10 busy clear", {31'd0, d[0]}, 32'd0);
    chk("R9 abort flag", {31'd0, d[1]}, (rl >= LIMIT) ? 32'd1 : 32'd0);
    rd(5, d);
    chk("R10 vertex count", d, 32'((h + 1) * (v + 1)));
    chk("R7/R9 write beats", 32'(beats), (rl >= LIMIT) ? 32'd0 : 32'(2 * (h + 1) * (v + 1)));
    if (rl < LIMIT) begin
      rd(6, d);
      chk("R8 last write address", d, vad(b, h, v) + 32'd4);
    end
    rd(2, d);
    chk("R11 last column kept", d, 32'(h));
    repeat (4) @(negedge clk);
    chk("R11 no restart", 32'(irq_cnt), 32'(c0 + 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    k = 0; runcnt = 0; beats = 0; irq_cnt = 0; wt = 0;
    cur_base = 0; cur_h = 0; cur_v = 0; cur_page = 0; runlen = 0; exp_run = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs idle", {28'd0, irq, mem_req, gpr_we, run_en}, 32'd0);
    for (int a = 0; a < 7; a++) begin
      rd(a, d);
      chk("R1 register reset", d, 32'd0);
    end
    for (int h = 0; h < 4; h++)
      for (int v = 0; v < 4; v++)
        sweep(32'h0040_0000 + h * 32'h1000 + v * 32'h10, h, v, (h + v) % 4, (h * 3 + v) % LIMIT, 1'b0);
    sweep(32'h0100_0000, 7, 7, 3, 0, 1'b0);
    sweep(32'h0200_0000, 1, 1, 1, LIMIT, 1'b0);
    sweep(32'h0300_0008, 2, 1, 2, 5, 1'b1);
    sweep(32'h0400_0000, 0, 0, 0, LIMIT - 1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule